// File: doc/BRIEF.md
# Alternating Two-Bank Frame Store

This block takes 8-bit pixels from an image sensor's parallel output and stores complete frames into two external asynchronous SRAMs. It uses the two SRAMs in turn. While one SRAM takes in the frame now arriving, the other plays the last complete frame out as a byte stream with a valid/ready handshake. Each SRAM bank holds exactly one frame. The frame size is set by width and height parameters, and the address space defaults to 21 bits.

Each bank carries a status flag: empty, being written, full or being read. A bank can be claimed for capture only when it is empty, and for readout only when it is full. Capture follows a write pointer and readout follows a read pointer. Each pointer moves to the other bank when its job on the current bank completes, so frames come out in the order they were stored. Capture begins only at the start of a frame, so a partial frame is never kept. A frame that starts while the next capture bank is still busy is dropped as a whole. The output side drains faster than the sensor fills. After it empties a bank, it therefore waits until the other bank has been completely written.

Top module: `pp_frame_store`

## Requirements
- R1: After reset both banks are empty, every SRAM chip-enable, write-enable and output-enable (all active low) is high, `out_valid` is low, and the first stored frame goes to bank 0.
- R2: Capture of a frame is claimed on the cycle where `pix_frame` rises. Each cycle with `pix_frame` and `pix_line` both high gives one SRAM write in the next clock. That write lasts one clock, with `ce_n` and `we_n` low, address equal to the pixel index counted from 0, and the pixel byte on the data pins.
- R3: Once FRAME_W×FRAME_H pixels have been written, the bank becomes full. Further pixels of that frame cause no writes, and the next frame goes to the other bank.
- R4: A full bank is read out in address order 0 to FRAME_W×FRAME_H−1. Each read holds `oe_n` and `ce_n` low for one clock, and the byte appears on `out_data` with `out_valid` high from the next clock on.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. The read address advances only on an accepted transfer.
- R6: Banks alternate, bank 0 then bank 1 and so on, and frames are streamed out in the order they were completed.
- R7: At most one bank is being written and at most one is being read at any time. A bank is never written and read in the same cycle.
- R8: A frame that starts while the next capture bank is full or being read is dropped completely, with no SRAM writes.
- R9: If `pix_frame` falls before a frame is complete, the partial data is discarded. The bank returns to empty, is never streamed, and takes the next frame.
- R10: A frame start in the same cycle as the final accepted byte of the bank that is next for capture is accepted. That frame is stored in that bank.
- R11: After emptying a bank, the reader produces no output until the other bank has been completely written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_data | input | DATA_W | Pixel byte from the sensor |
| pix_frame | input | 1 | Frame valid level |
| pix_line | input | 1 | Line valid level |
| sram0_addr | output | ADDR_W | Bank 0 address |
| sram0_dq | inout | DATA_W | Bank 0 data |
| sram0_ce_n | output | 1 | Bank 0 chip enable, active low |
| sram0_we_n | output | 1 | Bank 0 write enable, active low |
| sram0_oe_n | output | 1 | Bank 0 output enable, active low |
| sram1_addr | output | ADDR_W | Bank 1 address |
| sram1_dq | inout | DATA_W | Bank 1 data |
| sram1_ce_n | output | 1 | Bank 1 chip enable, active low |
| sram1_we_n | output | 1 | Bank 1 write enable, active low |
| sram1_oe_n | output | 1 | Bank 1 output enable, active low |
| out_data | output | DATA_W | Streamed byte |
| out_valid | output | 1 | Streamed byte is valid |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
Releasing a bank at the end of readout and claiming that same bank for a new frame can fall in the same cycle. The bench provokes this by holding `out_ready` low on the last byte of a bank while the other bank is full, so the write pointer points at the bank being read. It then raises `out_ready` and `pix_frame` together in one drive step. The case is judged by counting the SRAM writes into that bank, which must equal a full frame, and by checking that the new frame appears after the queued one in the output stream.

// File: rtl/fb_pkg.sv
package fb_pkg;
    typedef enum logic [1:0] {
        BANK_EMPTY   = 2'd0,
        BANK_WRITING = 2'd1,
        BANK_FULL    = 2'd2,
        BANK_READING = 2'd3
    } bank_state_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FETCH = 2'd1,
        RD_SHOW  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/fb_bank_ctrl.sv
module fb_bank_ctrl
    import fb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_claim,
    input  logic wr_done,
    input  logic wr_abort,
    input  logic rd_claim,
    input  logic rd_done,
    output logic wr_ok,
    output logic wr_bank,
    output logic rd_ok,
    output logic rd_bank
);
    localparam int NB = 2;

    typedef struct packed {
        bank_state_e [NB-1:0] st;
        logic                 wr_ptr;
        logic                 rd_ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        wr_bank = ctl_q.wr_ptr;
        rd_bank = ctl_q.rd_ptr;
        rd_ok   = (ctl_q.st[ctl_q.rd_ptr] == BANK_FULL);
        // a bank released by the reader this cycle may be claimed at once
        wr_ok   = (ctl_q.st[ctl_q.wr_ptr] == BANK_EMPTY) ||
                  ((ctl_q.st[ctl_q.wr_ptr] == BANK_READING) && rd_done &&
                   (ctl_q.rd_ptr == ctl_q.wr_ptr));
        if (rd_done) begin
            ctl_d.st[ctl_q.rd_ptr] = BANK_EMPTY;
            ctl_d.rd_ptr           = ~ctl_q.rd_ptr;
        end
        if (wr_done) begin
            ctl_d.st[ctl_q.wr_ptr] = BANK_FULL;
            ctl_d.wr_ptr           = ~ctl_q.wr_ptr;
        end
        if (wr_abort) ctl_d.st[ctl_q.wr_ptr] = BANK_EMPTY;
        if (wr_claim) ctl_d.st[ctl_q.wr_ptr] = BANK_WRITING;
        if (rd_claim) ctl_d.st[ctl_q.rd_ptr] = BANK_READING;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: {BANK_EMPTY, BANK_EMPTY}, wr_ptr: 1'b0, rd_ptr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((ctl_q.st[0] == BANK_WRITING) && (ctl_q.st[1] == BANK_WRITING)));
    assert_one_reader_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((ctl_q.st[0] == BANK_READING) && (ctl_q.st[1] == BANK_READING)));
    assert_read_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_claim |-> (ctl_q.st[ctl_q.rd_ptr] == BANK_FULL));
    assert_done_while_writing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || wr_abort) |-> (ctl_q.st[ctl_q.wr_ptr] == BANK_WRITING));
endmodule

// File: rtl/fb_capture.sv
module fb_capture #(
    parameter int FRAME_LEN = 16,
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_frame,
    input  logic              pix_line,
    input  logic              wr_ok,
    input  logic              wr_bank,
    output logic              wr_claim,
    output logic              wr_done,
    output logic              wr_abort,
    output logic              sram_wr,
    output logic              sram_bank,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_data
);
    typedef struct packed {
        logic              active;
        logic              frame;
        logic              bank;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic rise, take;
    logic [CNT_W-1:0] base, nxt;

    always_comb begin
        cap_d       = cap_q;
        cap_d.wr    = 1'b0;
        cap_d.frame = pix_frame;
        rise        = pix_frame & ~cap_q.frame;
        wr_claim    = ~cap_q.active & rise & wr_ok;
        wr_abort    = cap_q.active & ~pix_frame;
        wr_done     = 1'b0;
        base        = wr_claim ? '0 : cap_q.cnt;
        nxt         = base + CNT_W'(1);
        take        = (cap_q.active | wr_claim) & pix_frame & pix_line;
        if (wr_claim) begin
            cap_d.active = 1'b1;
            cap_d.bank   = wr_bank;
            cap_d.cnt    = '0;
        end
        if (wr_abort) cap_d.active = 1'b0;
        if (take) begin
            cap_d.wr   = 1'b1;
            cap_d.addr = ADDR_W'(base);
            cap_d.data = pix_data;
            cap_d.cnt  = nxt;
            if (nxt == CNT_W'(FRAME_LEN)) begin
                wr_done      = 1'b1;
                cap_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign sram_wr   = cap_q.wr;
    assign sram_bank = cap_q.bank;
    assign sram_addr = cap_q.addr;
    assign sram_data = cap_q.data;

    assert_addr_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.wr |-> (cap_q.addr < ADDR_W'(FRAME_LEN)));
    assert_done_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !cap_q.active);
endmodule

// File: rtl/fb_drain.sv
module fb_drain
    import fb_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  logic              rd_bank,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              out_ready,
    output logic              rd_claim,
    output logic              rd_done,
    output logic              rd_fetch,
    output logic              rd_sel,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        rd_state_e         st;
        logic              bank;
        logic [CNT_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } drn_t;

    drn_t drn_d, drn_q;

    always_comb begin
        drn_d    = drn_q;
        rd_claim = 1'b0;
        rd_done  = 1'b0;
        case (drn_q.st)
            RD_IDLE: if (rd_ok) begin
                rd_claim   = 1'b1;
                drn_d.bank = rd_bank;
                drn_d.idx  = '0;
                drn_d.st   = RD_FETCH;
            end
            RD_FETCH: begin
                drn_d.data = mem_rdata;
                drn_d.st   = RD_SHOW;
            end
            RD_SHOW: if (out_ready) begin
                if (drn_q.idx == CNT_W'(FRAME_LEN - 1)) begin
                    rd_done  = 1'b1;
                    drn_d.st = RD_IDLE;
                end else begin
                    drn_d.idx = drn_q.idx + CNT_W'(1);
                    drn_d.st  = RD_FETCH;
                end
            end
            default: drn_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drn_q <= '{st: RD_IDLE, bank: 1'b0, idx: '0, data: '0};
        else        drn_q <= drn_d;
    end

    assign rd_fetch  = (drn_q.st == RD_FETCH);
    assign rd_sel    = drn_q.bank;
    assign rd_addr   = ADDR_W'(drn_q.idx);
    assign out_valid = (drn_q.st == RD_SHOW);
    assign out_data  = drn_q.data;

    assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(rd_addr));
endmodule

// File: rtl/pp_frame_store.sv
module pp_frame_store #(
    parameter int FRAME_W = 1280,
    parameter int FRAME_H = 1024,
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_frame,
    input  logic              pix_line,
    output logic [ADDR_W-1:0] sram0_addr,
    inout  wire  [DATA_W-1:0] sram0_dq,
    output logic              sram0_ce_n,
    output logic              sram0_we_n,
    output logic              sram0_oe_n,
    output logic [ADDR_W-1:0] sram1_addr,
    inout  wire  [DATA_W-1:0] sram1_dq,
    output logic              sram1_ce_n,
    output logic              sram1_we_n,
    output logic              sram1_oe_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int FRAME_LEN = FRAME_W * FRAME_H;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int NB        = 2;

    logic wr_claim, wr_done, wr_abort, wr_ok, wr_ptr;
    logic rd_claim, rd_done, rd_ok, rd_ptr;
    logic              wr_en, wr_bank;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              rd_fetch, rd_sel;
    logic [NB-1:0]     bank_we_n, bank_oe_n, bank_ce_n;
    logic [ADDR_W-1:0] bank_addr [NB];

    fb_bank_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_claim(wr_claim), .wr_done(wr_done), .wr_abort(wr_abort),
        .rd_claim(rd_claim), .rd_done(rd_done),
        .wr_ok(wr_ok), .wr_bank(wr_ptr), .rd_ok(rd_ok), .rd_bank(rd_ptr)
    );

    fb_capture #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .pix_data(pix_data), .pix_frame(pix_frame), .pix_line(pix_line),
        .wr_ok(wr_ok), .wr_bank(wr_ptr),
        .wr_claim(wr_claim), .wr_done(wr_done), .wr_abort(wr_abort),
        .sram_wr(wr_en), .sram_bank(wr_bank), .sram_addr(wr_addr), .sram_data(wr_data)
    );

    fb_drain #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .rd_ok(rd_ok), .rd_bank(rd_ptr), .mem_rdata(rd_data), .out_ready(out_ready),
        .rd_claim(rd_claim), .rd_done(rd_done), .rd_fetch(rd_fetch), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .out_valid(out_valid), .out_data(out_data)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_we_n[b] = !(wr_en && (wr_bank == 1'(b)));
        assign bank_oe_n[b] = !(rd_fetch && (rd_sel == 1'(b)));
        assign bank_ce_n[b] = bank_we_n[b] & bank_oe_n[b];
        assign bank_addr[b] = bank_we_n[b] ? rd_addr : wr_addr;

        assert_no_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(!bank_we_n[b] && !bank_oe_n[b]));
    end

    assign sram0_addr = bank_addr[0];
    assign sram1_addr = bank_addr[1];
    assign sram0_we_n = bank_we_n[0];
    assign sram1_we_n = bank_we_n[1];
    assign sram0_oe_n = bank_oe_n[0];
    assign sram1_oe_n = bank_oe_n[1];
    assign sram0_ce_n = bank_ce_n[0];
    assign sram1_ce_n = bank_ce_n[1];
    assign sram0_dq   = bank_we_n[0] ? {DATA_W{1'bz}} : wr_data;
    assign sram1_dq   = bank_we_n[1] ? {DATA_W{1'bz}} : wr_data;
    assign rd_data    = rd_sel ? sram1_dq : sram0_dq;

    assert_single_write_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bank_we_n) <= 1);
endmodule

// File: tb/pp_frame_store_tb_top.sv
`timescale 1ns/1ps
module pp_frame_store_tb_top;
    localparam int W = 4;
    localparam int H = 3;
    localparam int LEN = W * H;
    localparam int AW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] pix_data = '0;
    logic pix_frame = 1'b0, pix_line = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] sram0_addr, sram1_addr;
    wire  [7:0] sram0_dq, sram1_dq;
    logic sram0_ce_n, sram0_we_n, sram0_oe_n, sram1_ce_n, sram1_we_n, sram1_oe_n;
    logic [7:0] out_data;
    logic out_valid;

    always #5 clk = ~clk;

    pp_frame_store #(.FRAME_W(W), .FRAME_H(H), .ADDR_W(AW), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_frame(pix_frame), .pix_line(pix_line),
        .sram0_addr(sram0_addr), .sram0_dq(sram0_dq), .sram0_ce_n(sram0_ce_n),
        .sram0_we_n(sram0_we_n), .sram0_oe_n(sram0_oe_n),
        .sram1_addr(sram1_addr), .sram1_dq(sram1_dq), .sram1_ce_n(sram1_ce_n),
        .sram1_we_n(sram1_we_n), .sram1_oe_n(sram1_oe_n),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    // SRAM models
    logic [7:0] mem0 [16];
    logic [7:0] mem1 [16];
    assign sram0_dq = (!sram0_ce_n && !sram0_oe_n && sram0_we_n) ? mem0[sram0_addr[3:0]] : 8'bz;
    assign sram1_dq = (!sram1_ce_n && !sram1_oe_n && sram1_we_n) ? mem1[sram1_addr[3:0]] : 8'bz;
    always @(posedge clk) begin
        if (!sram0_ce_n && !sram0_we_n) mem0[sram0_addr[3:0]] <= sram0_dq;
        if (!sram1_ce_n && !sram1_we_n) mem1[sram1_addr[3:0]] <= sram1_dq;
    end

    int checks = 0, errors = 0;
    int wc0 = 0, wc1 = 0, collide = 0, out_n = 0, exp_n = 0;
    logic [7:0] out_buf [128];
    logic [7:0] exp_buf [128];

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && out_n < 128) begin
                out_buf[out_n] = out_data;
                out_n++;
            end
            if (!sram0_we_n) wc0++;
            if (!sram1_we_n) wc1++;
            if ((!sram0_we_n && !sram0_oe_n) || (!sram1_we_n && !sram1_oe_n) ||
                (!sram0_we_n && !sram1_we_n) || (!sram0_oe_n && !sram1_oe_n) ||
                (!sram0_we_n && sram0_ce_n) || (!sram1_we_n && sram1_ce_n))
                collide++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] base);
        for (int i = 0; i < LEN; i++) begin
            exp_buf[exp_n] = base + 8'(i);
            exp_n++;
        end
    endtask

    task automatic check_stream(input string req);
        chk(out_n == exp_n, req, out_n, exp_n);
        for (int i = 0; i < exp_n && i < out_n; i++)
            chk(out_buf[i] == exp_buf[i], req, int'(out_buf[i]), int'(exp_buf[i]));
        out_n = 0;
        exp_n = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame_begin();
        @(posedge clk); #1 pix_frame = 1'b1;
    endtask

    task automatic frame_lines(input logic [7:0] base, input int nlines);
        for (int l = 0; l < nlines; l++) begin
            for (int x = 0; x < W; x++) begin
                @(posedge clk); #1;
                pix_line = 1'b1;
                pix_data = base + 8'(l * W + x);
            end
            @(posedge clk); #1 pix_line = 1'b0;
            cyc(2);
        end
    endtask

    task automatic frame_end();
        @(posedge clk); #1 pix_frame = 1'b0;
        cyc(2);
    endtask

    task automatic send_frame(input logic [7:0] base, input int nlines);
        frame_begin();
        frame_lines(base, nlines);
        frame_end();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sram0_ce_n && sram0_we_n && sram0_oe_n, "R1 bank0 strobes idle", int'(sram0_ce_n), 1);
        chk(sram1_ce_n && sram1_we_n && sram1_oe_n, "R1 bank1 strobes idle", int'(sram1_ce_n), 1);
        chk(!out_valid, "R1 out_valid low", int'(out_valid), 0);
    endtask

    task automatic t_single();
        out_ready = 1'b1; wc0 = 0; wc1 = 0;
        send_frame(8'h10, H);
        cyc(50);
        chk(wc0 == LEN, "R2 writes into bank0", wc0, LEN);
        chk(wc1 == 0, "R1 first frame not in bank1", wc1, 0);
        for (int i = 0; i < LEN; i++)
            chk(mem0[i] == 8'h10 + 8'(i), "R2 address equals pixel index", int'(mem0[i]), 16 + i);
        push_exp(8'h10);
        check_stream("R4 readout order");
    endtask

    task automatic t_alternate();
        out_ready = 1'b1; wc0 = 0; wc1 = 0;
        send_frame(8'h40, H + 1);
        send_frame(8'h80, H);
        cyc(60);
        chk(wc1 == LEN, "R3 extra pixels ignored, bank1 count", wc1, LEN);
        chk(wc0 == LEN, "R6 next frame to bank0", wc0, LEN);
        chk(mem1[0] == 8'h40 && mem0[0] == 8'h80, "R6 bank contents", int'(mem1[0]), 'h40);
        push_exp(8'h40); push_exp(8'h80);
        check_stream("R6 completion order");
    endtask

    task automatic t_backpressure();
        logic [7:0] held;
        out_ready = 1'b0;
        send_frame(8'hC0, H);
        cyc(10);
        @(negedge clk);
        held = out_data;
        chk(out_valid && out_data == 8'hC0, "R5 first byte presented", int'(out_data), 'hC0);
        cyc(5);
        @(negedge clk);
        chk(out_valid && out_data == held, "R5 byte held without ready", int'(out_data), int'(held));
        send_frame(8'hD0, H);
        wc0 = 0; wc1 = 0;
        send_frame(8'hE0, H);
        cyc(5);
        chk(wc0 + wc1 == 0, "R8 frame dropped when both busy", wc0 + wc1, 0);
        out_ready = 1'b1;
        cyc(80);
        push_exp(8'hC0); push_exp(8'hD0);
        check_stream("R8 dropped frame absent from stream");
    endtask

    task automatic t_abort();
        out_ready = 1'b1; wc0 = 0; wc1 = 0;
        send_frame(8'h20, 1);
        cyc(40);
        chk(wc1 == W, "R9 partial frame written to bank1", wc1, W);
        chk(out_n == 0, "R9 partial frame not streamed", out_n, 0);
        send_frame(8'h30, H);
        cyc(50);
        chk(wc1 == W + LEN, "R9 aborted bank reused", wc1, W + LEN);
        chk(wc0 == 0, "R9 bank0 untouched", wc0, 0);
        push_exp(8'h30);
        check_stream("R9 stream after abort");
    endtask

    task automatic t_stall();
        out_ready = 1'b1;
        frame_begin();
        frame_lines(8'h90, H - 1);
        @(negedge clk);
        chk(out_n == 0 && !out_valid, "R11 reader waits for full bank", out_n, 0);
        frame_lines(8'h90 + 8'((H - 1) * W), 1);
        frame_end();
        cyc(50);
        push_exp(8'h90);
        check_stream("R11 stream after wait");
    endtask

    task automatic t_same_cycle();
        out_ready = 1'b0;
        send_frame(8'h60, H);
        send_frame(8'h70, H);
        for (int k = 0; k < LEN - 1; k++) begin
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            @(posedge clk); #1 out_ready = 1'b1;
            @(posedge clk); #1 out_ready = 1'b0;
        end
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        chk(out_data == 8'h60 + 8'(LEN - 1), "R10 last byte shown", int'(out_data), 'h60 + LEN - 1);
        wc0 = 0; wc1 = 0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        pix_frame = 1'b1;
        @(posedge clk); #1 out_ready = 1'b0;
        frame_lines(8'hA0, H);
        frame_end();
        chk(wc1 == LEN, "R10 frame start on release stored", wc1, LEN);
        chk(wc0 == 0, "R10 other bank untouched", wc0, 0);
        out_ready = 1'b1;
        cyc(90);
        push_exp(8'h60); push_exp(8'h70); push_exp(8'hA0);
        check_stream("R10 order across release");
        chk(collide == 0, "R7 exclusive bank access", collide, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_alternate();
        t_backpressure();
        t_abort();
        t_stall();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule